// File: doc/BRIEF.md
# Consecutive Over-Temperature Shutdown Queue

This block decides when a board must be shut down for heat. It keeps one qualification queue per temperature channel. Each queue counts back-to-back measurements that are over that channel's trip limit. When a queue is full and its channel is enabled for shutdown, the block pulls an active-low shutdown line. One channel, the first remote sensor, also has a second, fixed emergency limit. It trips on that limit even while its programmable limit sits higher.

A tripped channel does not clear when the next reading falls under the limit. It holds until a reading falls below the limit minus that channel's hysteresis. All channels share one 3-bit queue-length field. A channel only takes a new value of that field while its own queue is empty, so a count already in progress is never shortened or lengthened part-way through. Measurement conversion, the host bus and register storage sit outside this block. The block sees only per-channel strobes, temperatures, limits, hysteresis values, the link mask and the length field.

Top module: `thrm_shdn_queue`

## Requirements
- R1: The queue length is one plus the number of ones in `cnt_code`. Thus 000 needs 1 measurement, 001 needs 2, 011 needs 3 and 111 needs 4. After reset each channel holds a length of 4 until its queue first takes the field.
- R2: A strobed measurement counts as over only when the temperature is strictly greater than that channel's trip limit. A reading equal to the limit is not over.
- R3: Channel `HW_CH` (default 1) is also over when its temperature is greater than or equal to `hw_lim`, even when its own trip limit is higher. No other channel looks at `hw_lim`.
- R4: While a channel is not tripped, a strobed measurement that is not over clears that channel's count to zero.
- R5: A channel trips on the strobe that brings its count up to its queue length. If the channel is linked, `shdn_n` is low from the clock edge that takes that strobe onward.
- R6: A tripped channel stays tripped while each strobed reading is at least (limit − hysteresis), floored at 0. For channel `HW_CH` this floor is taken from either of its two limits. The first strobed reading below every applicable floor clears the channel and its count.
- R7: `shdn_n` is low exactly when at least one channel whose `link_mask` bit is 1 is tripped. A change of `link_mask` reaches `shdn_n` without a clock. Unlinked channels still count and trip, but they never move `shdn_n`.
- R8: A channel whose count is non-zero or that is tripped keeps the queue length it had when its count started, whatever `cnt_code` does. A channel with an empty queue uses the current `cnt_code` at once.
- R9: A synchronous reset (`rst_n` low at a clock edge) clears every count and trip, so `shdn_n` is high after that edge.
- R10: On a clock edge with a channel's strobe low, that channel's count and trip state do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| meas_vld | input | NCH | Per-channel measurement strobe, one cycle per new reading |
| meas_temp | input | NCH*TW | Per-channel temperature, unsigned, channel c in bits [c*TW +: TW] |
| trip_lim | input | NCH*TW | Per-channel trip limit |
| trip_hyst | input | NCH*TW | Per-channel release hysteresis |
| hw_lim | input | TW | Fixed emergency limit for channel HW_CH |
| link_mask | input | NCH | 1 lets the channel drive shutdown |
| cnt_code | input | 3 | Shared queue-length field |
| shdn_n | output | 1 | Active-low shutdown request |

## Verification
The queues are driven with readings that sit exactly on each edge: equal to the trip limit, one above it, equal to the emergency limit, and exactly on the release floor or one under it. These show whether each comparison is strict or inclusive, and whether the hold and release use the right floor. Broken runs of over-limit readings show the difference between a count that clears and one that only pauses. A length field rewritten in the middle of a run shows the difference between a latched length and a live one. Link-mask changes while a channel is tripped show whether the output is masked or the trip itself is suppressed. A long random phase with mixed strobes, lengths and masks is then compared cycle by cycle against a behavioural model.

// File: rtl/thrm_pkg.sv
// Shared definitions for the shutdown queue: length-field width, the
// counter type and the decode from the length field to a queue length.
package thrm_pkg;
    localparam int CODE_W = 3;
    localparam int QMAX   = CODE_W + 1;
    localparam int QCW    = $clog2(QMAX + 1);

    typedef logic [QCW-1:0]    qcnt_t;
    typedef logic [CODE_W-1:0] qcode_t;

    // Queue length is one plus the number of set bits in the field.
    function automatic qcnt_t code_to_len(input qcode_t c);
        qcnt_t n;
        n = qcnt_t'(1);
        for (int i = 0; i < CODE_W; i++) begin
            n = n + qcnt_t'(c[i]);
        end
        return n;
    endfunction
endpackage

// File: rtl/thrm_cmp.sv
// Limit comparator for one channel.
// Produces "over" (this reading counts toward the queue) and "warm" (the
// reading is still at or above the release floor). The floor is the limit
// minus the hysteresis, clamped at zero. With HW_EN the emergency limit is
// folded into both results. Assumes unsigned temperatures.
module thrm_cmp #(
    parameter int TW    = 8,
    parameter bit HW_EN = 1'b0
) (
    input  logic [TW-1:0] temp,
    input  logic [TW-1:0] lim,
    input  logic [TW-1:0] hyst,
    input  logic [TW-1:0] hw_lim,
    output logic          over,
    output logic          warm
);
    logic [TW-1:0] lim_floor;
    logic          lim_over;
    logic          lim_warm;

    // Clamped release floor for the programmable limit.
    always_comb begin
        lim_floor = (lim > hyst) ? (lim - hyst) : '0;
        lim_over  = (temp > lim);
        lim_warm  = (temp >= lim_floor);
    end

    generate
        if (HW_EN) begin : g_hw
            logic [TW-1:0] hw_floor;
            // Emergency limit is inclusive and shares the channel hysteresis.
            always_comb begin
                hw_floor = (hw_lim > hyst) ? (hw_lim - hyst) : '0;
                over     = lim_over | (temp >= hw_lim);
                warm     = lim_warm | (temp >= hw_floor);
            end
        end else begin : g_plain
            // Plain channel: only the programmable limit applies.
            always_comb begin
                over = lim_over;
                warm = lim_warm;
            end
        end
    endgenerate
endmodule

// File: rtl/thrm_chan.sv
// One channel's qualification queue.
// Counts consecutive over-limit strobes up to a latched length and then
// sets the trip flag. Once tripped, it holds until a strobed reading falls
// below the release floor. The length is re-read from the shared field
// only while the queue is empty. Assumes a strobe lasts one cycle per reading.
module thrm_chan
    import thrm_pkg::*;
#(
    parameter int TW    = 8,
    parameter bit HW_EN = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vld,
    input  logic [TW-1:0] temp,
    input  logic [TW-1:0] lim,
    input  logic [TW-1:0] hyst,
    input  logic [TW-1:0] hw_lim,
    input  qcode_t        code,
    output logic          trip,
    output qcnt_t         cnt
);
    logic  over;
    logic  warm;
    logic  empty;
    qcnt_t len_q;
    qcnt_t len_eff;
    qcnt_t cnt_inc;

    thrm_cmp #(.TW(TW), .HW_EN(HW_EN)) u_cmp (
        .temp   (temp),
        .lim    (lim),
        .hyst   (hyst),
        .hw_lim (hw_lim),
        .over   (over),
        .warm   (warm)
    );

    // Pick the live length when the queue is empty, else keep the latched one.
    always_comb begin
        empty   = (cnt == '0) && !trip;
        len_eff = empty ? code_to_len(code) : len_q;
        cnt_inc = cnt + qcnt_t'(1);
    end

    // Length latch, counter and trip flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q <= qcnt_t'(QMAX);
            cnt   <= '0;
            trip  <= 1'b0;
        end else begin
            len_q <= len_eff;
            if (vld) begin
                if (trip) begin
                    if (!warm) begin
                        trip <= 1'b0;
                        cnt  <= '0;
                    end
                end else if (over) begin
                    cnt <= cnt_inc;
                    if (cnt_inc >= len_eff) begin
                        trip <= 1'b1;
                    end
                end else begin
                    cnt <= '0;
                end
            end
        end
    end
endmodule

// File: rtl/thrm_merge.sv
// Output merge: active-low shutdown whenever any linked channel is tripped.
// Purely combinational, so a link-mask change acts at once.
module thrm_merge #(
    parameter int NCH = 4
) (
    input  logic [NCH-1:0] trip,
    input  logic [NCH-1:0] link,
    output logic           shdn_n
);
    // Reduce the linked trip flags.
    always_comb begin
        shdn_n = ~|(trip & link);
    end
endmodule

// File: rtl/thrm_shdn_queue.sv
// Top of the consecutive over-temperature shutdown queue.
// Builds NCH channel queues. Channel HW_CH also gets the emergency-limit
// comparator. The trip flags are merged into one active-low output.
// Assumes all inputs are synchronous to clk.
module thrm_shdn_queue
    import thrm_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int TW    = 8,
    parameter int HW_CH = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    meas_vld,
    input  logic [NCH*TW-1:0] meas_temp,
    input  logic [NCH*TW-1:0] trip_lim,
    input  logic [NCH*TW-1:0] trip_hyst,
    input  logic [TW-1:0]     hw_lim,
    input  logic [NCH-1:0]    link_mask,
    input  logic [CODE_W-1:0] cnt_code,
    output logic              shdn_n
);
    localparam int CNT_BITS = NCH * QCW;

    logic [NCH-1:0]      chan_trip;
    logic [CNT_BITS-1:0] chan_cnt;

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_ch
            qcnt_t c_cnt;
            thrm_chan #(.TW(TW), .HW_EN(g == HW_CH)) u_chan (
                .clk    (clk),
                .rst_n  (rst_n),
                .vld    (meas_vld[g]),
                .temp   (meas_temp[g*TW +: TW]),
                .lim    (trip_lim[g*TW +: TW]),
                .hyst   (trip_hyst[g*TW +: TW]),
                .hw_lim (hw_lim),
                .code   (cnt_code),
                .trip   (chan_trip[g]),
                .cnt    (c_cnt)
            );
            assign chan_cnt[g*QCW +: QCW] = c_cnt;
        end
    endgenerate

    thrm_merge #(.NCH(NCH)) u_merge (
        .trip   (chan_trip),
        .link   (link_mask),
        .shdn_n (shdn_n)
    );
endmodule

// File: rtl/thrm_shdn_chk.sv
// Property checker for thrm_shdn_queue, bound into every instance.
module thrm_shdn_chk
    import thrm_pkg::*;
#(
    parameter int NCH = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NCH-1:0]     meas_vld,
    input logic [NCH-1:0]     link_mask,
    input logic [NCH-1:0]     trip,
    input logic [NCH*QCW-1:0] cnt_flat,
    input logic               shdn_n
);
    // R7: a low output needs a linked, tripped channel.
    a_r7_link_only: assert property (@(posedge clk) disable iff (!rst_n)
        !shdn_n |-> |(trip & link_mask));

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_p
            // R10: no strobe, no change of trip or count.
            a_r10_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
                !meas_vld[g] |=> ($stable(trip[g]) && $stable(cnt_flat[g*QCW +: QCW])));
            // R5: a trip only appears after a strobe.
            a_r5_set_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
                (!meas_vld[g] && !trip[g]) |=> !trip[g]);
            // R1: the count never passes the longest queue.
            a_r1_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
                cnt_flat[g*QCW +: QCW] <= qcnt_t'(QMAX));
            // R4: a tripped channel always has a non-empty count.
            a_r4_trip_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
                trip[g] |-> (cnt_flat[g*QCW +: QCW] != '0));
        end
    endgenerate
endmodule

bind thrm_shdn_queue thrm_shdn_chk #(.NCH(NCH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .meas_vld  (meas_vld),
    .link_mask (link_mask),
    .trip      (chan_trip),
    .cnt_flat  (chan_cnt),
    .shdn_n    (shdn_n)
);

// File: tb/sim_thrm_shdn_queue.sv
`timescale 1ns/1ps
module sim_thrm_shdn_queue;
    localparam int NCH = 4;
    localparam int TW  = 8;
    localparam int HW  = 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NCH-1:0]    meas_vld = '0;
    logic [NCH*TW-1:0] meas_temp = '0;
    logic [NCH*TW-1:0] trip_lim = '0;
    logic [NCH*TW-1:0] trip_hyst = '0;
    logic [TW-1:0]     hw_lim = '0;
    logic [NCH-1:0]    link_mask = '1;
    logic [2:0]        cnt_code = 3'b000;
    logic              shdn_n;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;

    int m_cnt [NCH];
    bit m_trip [NCH];
    int m_len [NCH];

    always #4 clk = ~clk;

    thrm_shdn_queue #(.NCH(NCH), .TW(TW), .HW_CH(HW)) u0 (
        .clk(clk), .rst_n(rst_n), .meas_vld(meas_vld), .meas_temp(meas_temp),
        .trip_lim(trip_lim), .trip_hyst(trip_hyst), .hw_lim(hw_lim),
        .link_mask(link_mask), .cnt_code(cnt_code), .shdn_n(shdn_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    function automatic int fl(input int a, input int b);
        return (a > b) ? a - b : 0;
    endfunction

    // Behavioural reference model, updated on each clock edge.
    always @(posedge clk) begin
        cyc++;
        for (int c = 0; c < NCH; c++) begin
            if (!rst_n) begin
                m_cnt[c] = 0; m_trip[c] = 0; m_len[c] = 4;
            end else begin
                int t, l, h, len;
                bit hot, keep;
                t = meas_temp[c*TW +: TW];
                l = trip_lim[c*TW +: TW];
                h = trip_hyst[c*TW +: TW];
                len = (m_cnt[c] == 0 && !m_trip[c]) ? 1 + $countones(cnt_code) : m_len[c];
                m_len[c] = len;
                if (meas_vld[c]) begin
                    hot  = (t > l) || (c == HW && t >= int'(hw_lim));
                    keep = (t >= fl(l, h)) || (c == HW && t >= fl(int'(hw_lim), h));
                    if (m_trip[c]) begin
                        if (!keep) begin m_trip[c] = 0; m_cnt[c] = 0; end
                    end else if (hot) begin
                        m_cnt[c]++;
                        if (m_cnt[c] >= len) m_trip[c] = 1;
                    end else begin
                        m_cnt[c] = 0;
                    end
                end
            end
        end
    end

    // Per-cycle comparison against the model (R5, R7).
    always @(negedge clk) begin
        #2;
        if (rst_n && !done) begin
            bit e;
            e = 1'b1;
            for (int c = 0; c < NCH; c++) if (m_trip[c] && link_mask[c]) e = 1'b0;
            chk(shdn_n === e, "R5/R7 model", int'(shdn_n), int'(e));
        end
    end

    task automatic meas(input logic [NCH-1:0] m, input int t);
        for (int c = 0; c < NCH; c++) if (m[c]) meas_temp[c*TW +: TW] = TW'(t);
        meas_vld = m;
        @(negedge clk);
        meas_vld = '0;
    endtask

    task automatic expect_out(input bit e, input string req);
        #1;
        chk(shdn_n === e, req, int'(shdn_n), int'(e));
    endtask

    // Watchdog.
    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: got 0 expected 1 (run completed)");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int c = 0; c < NCH; c++) begin
            trip_lim[c*TW +: TW]  = (c == HW) ? 8'd100 : 8'd70;
            trip_hyst[c*TW +: TW] = 8'd5;
        end
        hw_lim = 8'd60;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        expect_out(1'b1, "R9 reset");

        // R1/R2: length 1, equal is not over, one above trips.
        cnt_code = 3'b000;
        meas(4'b0001, 70); expect_out(1'b1, "R2 equal limit");
        meas(4'b0001, 71); expect_out(1'b0, "R1 R5 len1 trip");
        // R6: hold at floor, release under it.
        meas(4'b0001, 73); expect_out(1'b0, "R6 hold above");
        meas(4'b0001, 65); expect_out(1'b0, "R6 hold at floor");
        meas(4'b0001, 64); expect_out(1'b1, "R6 release");

        // R1: length 3.
        cnt_code = 3'b011;
        meas(4'b0100, 71); meas(4'b0100, 71); expect_out(1'b1, "R1 len3 two");
        meas(4'b0100, 71); expect_out(1'b0, "R1 len3 three");
        // R10: idle cycles with cold temperatures change nothing.
        meas_temp[2*TW +: TW] = 8'd0;
        repeat (5) @(negedge clk);
        expect_out(1'b0, "R10 idle hold");
        meas(4'b0100, 50); expect_out(1'b1, "R6 release ch2");

        // R4: a broken run restarts.
        cnt_code = 3'b001;
        meas(4'b1000, 71); meas(4'b1000, 70); meas(4'b1000, 71);
        expect_out(1'b1, "R4 run cleared");
        meas(4'b1000, 71); expect_out(1'b0, "R4 two after clear");
        meas(4'b1000, 10); expect_out(1'b1, "R6 release ch3");

        // R3: emergency limit on channel HW only.
        cnt_code = 3'b000;
        meas(4'b0010, 59); expect_out(1'b1, "R3 below hw limit");
        meas(4'b0001, 60); expect_out(1'b1, "R3 other channel ignores hw");
        meas(4'b0010, 60); expect_out(1'b0, "R3 at hw limit");
        meas(4'b0010, 56); expect_out(1'b0, "R6 hw hold");
        meas(4'b0010, 54); expect_out(1'b1, "R6 hw release");

        // R7: unlinked channel trips silently.
        link_mask = 4'b1110;
        meas(4'b0001, 71); expect_out(1'b1, "R7 unlinked");
        link_mask = 4'b1111; expect_out(1'b0, "R7 relink");
        meas(4'b0001, 40); expect_out(1'b1, "R7 release");

        // R8: length latched while counting.
        cnt_code = 3'b111;
        meas(4'b0100, 71); meas(4'b0100, 71);
        cnt_code = 3'b000;
        meas(4'b0100, 71); expect_out(1'b1, "R8 latched len");
        meas(4'b0100, 71); expect_out(1'b0, "R8 len4 reached");
        meas(4'b0100, 40); expect_out(1'b1, "R8 release");
        meas(4'b0100, 71); expect_out(1'b0, "R8 empty takes new");
        meas(4'b0100, 40);

        // Random phase against the model.
        for (int i = 0; i < 3000; i++) begin
            if (i % 50 == 0) cnt_code = 3'($urandom_range(0, 7));
            if (i % 97 == 0) link_mask = 4'($urandom_range(0, 15));
            for (int c = 0; c < NCH; c++)
                meas_temp[c*TW +: TW] = 8'($urandom_range(50, 105));
            meas_vld = 4'($urandom_range(0, 15));
            @(negedge clk);
        end
        meas_vld = '0;

        // R9: reset while tripped.
        link_mask = 4'b1111;
        cnt_code = 3'b000;
        meas(4'b0001, 90); expect_out(1'b0, "R5 before reset");
        rst_n = 1'b0;
        @(negedge clk);
        expect_out(1'b1, "R9 reset clears");
        rst_n = 1'b1;
        @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule